// File: doc/BRIEF.md
# Clock-Stop SPI Serial Port

This block is a synchronous serial port that runs in a clock-stop SPI arrangement. It can act as the bus master or as a slave, chosen by a mode input. The serial clock toggles only while a word is moving. When the port is idle the clock rests low.

As master, the port divides a reference into the serial clock. The reference is either the system clock or an external clock. An internal active-high frame-sync is inverted to drive an active-low slave-select. The port shifts one word out on the data output, most significant bit first, and captures an equal-length word from the data input. The select asserts ahead of the first clock pulse by a lead time set by the clock's low width. It releases a high-width after the final rising edge, and the data output enable drops at the same moment.

As slave, the port takes the serial clock and active-low select as inputs. It samples them at half the system clock rate. It presents the next bit on each rising edge while selected and captures on each falling edge. A one-cycle start pulse loads the transmit word, and a one-cycle done pulse marks a valid received word.

Top module: `spi_clkstop_port`

## Requirements
- R1: After reset, ssel_n_o is 1, sclk_o is 0, dx_oe is 0, done is 0 and rx_word is 0.
- R2: In master mode, a start pulse sampled at a clock edge drives ssel_n_o low at that edge. With reference ticks on every system clock and effective divider D, sclk_o first rises L = floor((D+1)/2) ticks later. At that same edge dx_oe goes high and the first data bit appears.
- R3: The master serial clock has a period of D+1 reference ticks. Within each period it is low for the first L ticks and high for the remaining D+1-L ticks. It makes exactly WORD_W pulses per transfer and stays low between transfers.
- R4: The master sends tx_word, as sampled at the start pulse, most significant bit first on dx_o. Each bit changes only at a rising sclk_o edge.
- R5: The master captures dr_i at each falling sclk_o edge, most significant bit first. The assembled word appears on rx_word together with done.
- R6: WORD_W*(D+1) ticks after the select falls, which is D+1-L ticks after the last rising edge, ssel_n_o returns high and dx_oe returns low. At that same edge sclk_o falls and done pulses for exactly one cycle.
- R7: A divider setting of 0 behaves as a setting of 1.
- R8: With ref_int at 0, reference ticks are the rising edges of ext_ref. The serial period is then D+1 ext_ref periods and the high width is D+1-L ext_ref periods.
- R9: A start pulse that arrives while a master transfer is running has no effect on that transfer's output bits, timing or received word.
- R10: In slave mode, sclk_o stays 0 and ssel_n_o stays 1. While ssel_n_i is low, each rising sclk_i edge presents the next bit of the loaded word, most significant bit first, with dx_oe high. Each falling edge captures dr_i, and the WORD_W-th falling edge gives one done pulse with the word on rx_word.
- R11: In slave mode, dx_oe is 0 before the first rising sclk_i edge of a frame and returns to 0 after ssel_n_i goes high.
- R12: The divider setting is latched at the start pulse, so changing div_set during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| ref_int | input | 1 | 1: system clock is the divider reference; 0: ext_ref is the reference |
| ext_ref | input | 1 | External reference clock, synchronized internally |
| div_set | input | DIV_W | Divider setting D; the serial period is D+1 reference ticks |
| start | input | 1 | One-cycle pulse that loads tx_word (and starts a master transfer) |
| tx_word | input | WORD_W | Word to transmit |
| dr_i | input | 1 | Serial data input |
| sclk_i | input | 1 | Serial clock input in slave mode |
| ssel_n_i | input | 1 | Active-low select input in slave mode |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle pulse when rx_word is updated |
| sclk_o | output | 1 | Serial clock output in master mode |
| ssel_n_o | output | 1 | Active-low slave-select output in master mode |
| dx_o | output | 1 | Serial data output value |
| dx_oe | output | 1 | Output enable for dx_o; 0 means high impedance |

## Verification
The hardest case to reach is a master transfer disturbed in flight. The bench produces it by pulsing start with a different word mid-transfer, and in a separate run by rewriting the divider mid-transfer. In both runs a closed-form timeline is computed from the start cycle and compared on every clock, so any change in edge timing or bit sequence shows up. The slave path is driven with slow, hand-built select and clock waveforms. Outputs are sampled well clear of the half-rate sampling latency.

// File: rtl/spi_clkstop_port.sv
module spi_clkstop_port #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              ref_int,
  input  logic              ext_ref,
  input  logic [DIV_W-1:0]  div_set,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              dr_i,
  input  logic              sclk_i,
  input  logic              ssel_n_i,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              sclk_o,
  output logic              ssel_n_o,
  output logic              dx_o,
  output logic              dx_oe
);
  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [2:0]        ext_q;
  logic              half_en;
  logic              ref_tick;
  logic [DIV_W-1:0]  div_eff;
  logic [CNT_W-1:0]  per_new, per, low_w, phase;
  logic              m_busy, sclk_r;
  logic [BIT_W-1:0]  bits;
  logic [WORD_W-1:0] shreg, rxreg;
  logic              sy_clk, sy_sel, s_clk, s_clk_d, s_sel, s_sel_d;

  assign div_eff  = (div_set == '0) ? DIV_W'(1) : div_set;
  assign per_new  = {1'b0, div_eff} + CNT_W'(1);
  assign ref_tick = ref_int | (ext_q[1] & ~ext_q[2]);
  assign sclk_o   = is_master & sclk_r;
  assign ssel_n_o = ~(is_master & m_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= '0;
      half_en <= 1'b0;
      sy_clk  <= 1'b0;
      sy_sel  <= 1'b0;
    end else begin
      ext_q   <= {ext_q[1:0], ext_ref};
      half_en <= ~half_en;
      sy_clk  <= sclk_i;
      sy_sel  <= ~ssel_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  <= 1'b0;
      sclk_r  <= 1'b0;
      per     <= '0;
      low_w   <= '0;
      phase   <= '0;
      bits    <= '0;
      shreg   <= '0;
      rxreg   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      dx_o    <= 1'b0;
      dx_oe   <= 1'b0;
      s_clk   <= 1'b0;
      s_clk_d <= 1'b0;
      s_sel   <= 1'b0;
      s_sel_d <= 1'b0;
    end else begin
      done <= 1'b0;
      if (is_master) begin
        if (!m_busy) begin
          if (start) begin
            m_busy <= 1'b1;
            phase  <= '0;
            bits   <= '0;
            shreg  <= tx_word;
            per    <= per_new;
            low_w  <= per_new >> 1;
          end
        end else if (ref_tick) begin
          phase <= phase + CNT_W'(1);
          if (phase == low_w - CNT_W'(1)) begin
            sclk_r <= 1'b1;
            dx_o   <= shreg[WORD_W-1];
            dx_oe  <= 1'b1;
            shreg  <= shreg << 1;
          end
          if (phase == per - CNT_W'(1)) begin
            sclk_r <= 1'b0;
            phase  <= '0;
            rxreg  <= (rxreg << 1) | WORD_W'(dr_i);
            bits   <= bits + BIT_W'(1);
            if (bits == LAST_BIT) begin
              m_busy  <= 1'b0;
              dx_oe   <= 1'b0;
              done    <= 1'b1;
              rx_word <= (rxreg << 1) | WORD_W'(dr_i);
            end
          end
        end
      end else begin
        if (start && !s_sel) shreg <= tx_word;
        if (half_en) begin
          s_clk   <= sy_clk;
          s_clk_d <= s_clk;
          s_sel   <= sy_sel;
          s_sel_d <= s_sel;
          if (s_sel) begin
            if (!s_sel_d) begin
              bits  <= '0;
              rxreg <= '0;
            end
            if (s_clk && !s_clk_d) begin
              dx_o  <= shreg[WORD_W-1];
              dx_oe <= 1'b1;
              shreg <= shreg << 1;
            end
            if (!s_clk && s_clk_d) begin
              rxreg <= (rxreg << 1) | WORD_W'(dr_i);
              bits  <= bits + BIT_W'(1);
              if (bits == LAST_BIT) begin
                done    <= 1'b1;
                rx_word <= (rxreg << 1) | WORD_W'(dr_i);
              end
            end
          end else begin
            dx_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module spi_clkstop_port_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic done,
  input logic sclk_o,
  input logic ssel_n_o,
  input logic dx_oe
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (ssel_n_o && !sclk_o));
  assert_clk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !ssel_n_o);
  assert_oe_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && dx_oe) |-> !ssel_n_o);
  assert_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n_o) |-> (!sclk_o && !dx_oe));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $rose(ssel_n_o)) |-> (done && !dx_oe && !sclk_o));
endmodule

bind spi_clkstop_port spi_clkstop_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .done(done),
  .sclk_o(sclk_o), .ssel_n_o(ssel_n_o), .dx_oe(dx_oe)
);

// File: tb/spi_clkstop_port_bench.sv
`timescale 1ns/1ps
module spi_clkstop_port_bench;
  localparam int N = 8;
  localparam int DW = 8;
  localparam int HP = 12;

  logic clk = 0, rst_n = 0, is_master = 1, ref_int = 1, ext_ref = 0;
  logic [DW-1:0] div_set = 1;
  logic start = 0, dr_i = 0, sclk_i = 0, ssel_n_i = 1;
  logic [N-1:0] tx_word = 0, rx_word;
  logic done, sclk_o, ssel_n_o, dx_o, dx_oe;

  spi_clkstop_port #(.WORD_W(N), .DIV_W(DW)) u_spi_clkstop_port (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .ref_int(ref_int),
    .ext_ref(ext_ref), .div_set(div_set), .start(start), .tx_word(tx_word),
    .dr_i(dr_i), .sclk_i(sclk_i), .ssel_n_i(ssel_n_i), .rx_word(rx_word),
    .done(done), .sclk_o(sclk_o), .ssel_n_o(ssel_n_o), .dx_o(dx_o), .dx_oe(dx_oe));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // master reference model state
  bit mon_on = 0;
  int cs = 0, mT = 2, mL = 1;
  logic [N-1:0] mtx = 0, mrx = 0;
  int rises = 0, done_cnt = 0;
  logic prev_sclk = 0;
  int rise_c0 = 0, rise_c1 = 0, fall_c0 = 0;
  bit ext_on = 0;
  int ecnt = 0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mon_on) begin
      int e, k;
      bit ex_ssel, ex_sclk, ex_oe, ex_done;
      e = cyc - cs;
      ex_ssel = !(e < N*mT);
      ex_sclk = (e < N*mT) && ((e % mT) >= mL);
      ex_oe = (e >= mL) && (e < N*mT);
      ex_done = (e == N*mT);
      chk(ssel_n_o == ex_ssel, "R2/R6 ssel_n_o", ssel_n_o, ex_ssel);
      chk(sclk_o == ex_sclk, "R3 sclk_o", sclk_o, ex_sclk);
      chk(dx_oe == ex_oe, "R2/R6 dx_oe", dx_oe, ex_oe);
      chk(done == ex_done, "R6 done", done, ex_done);
      if (ex_oe) begin
        k = (e - mL) / mT;
        chk(dx_o == mtx[N-1-k], "R4 dx_o", dx_o, mtx[N-1-k]);
      end
      if (e >= N*mT) chk(rx_word == mrx, "R5 rx_word", rx_word, mrx);
    end
    if (is_master) begin
      if (sclk_o && !prev_sclk) begin
        if (rises == 0) rise_c0 = cyc;
        if (rises == 1) rise_c1 = cyc;
        if (rises < N) dr_i = mrx[N-1-rises];
        rises++;
      end
      if (!sclk_o && prev_sclk && rises == 1) fall_c0 = cyc;
    end
    prev_sclk = sclk_o;
    if (ext_on) begin
      ecnt++;
      if (ecnt == 3) begin ext_ref = ~ext_ref; ecnt = 0; end
    end
  end

  task automatic launch(input logic [N-1:0] tx, input logic [N-1:0] rx, input int d);
    int de;
    @(negedge clk);
    de = (d == 0) ? 1 : d;
    tx_word = tx; div_set = DW'(d); mtx = tx; mrx = rx;
    mT = de + 1; mL = (de + 1) / 2;
    rises = 0; done_cnt = 0;
    start = 1; cs = cyc + 1;
    @(negedge clk);
    start = 0;
  endtask

  // mode 0 plain, 1 restart mid-flight (R9), 2 divider change mid-flight (R12)
  task automatic run_master(input logic [N-1:0] tx, input logic [N-1:0] rx, input int d, input int mode);
    launch(tx, rx, d);
    mon_on = 1;
    for (int i = 0; i < N*mT + 4; i++) begin
      if (i == 5 && mode == 1) begin tx_word = ~tx; start = 1; end
      if (i == 6) start = 0;
      if (i == 5 && mode == 2) div_set = DW'(d + 3);
      @(negedge clk);
    end
    mon_on = 0;
    if (mode == 1) chk(rx_word == rx && done_cnt == 1, "R9 restart ignored", rx_word, rx);
    if (mode == 2) chk(rx_word == rx && done_cnt == 1, "R12 divider latched", rx_word, rx);
    if (d == 0) chk(rx_word == rx, "R7 divider zero as one", rx_word, rx);
    chk(done_cnt == 1, "R6 one done per transfer", done_cnt, 1);
  endtask

  task automatic run_slave(input logic [N-1:0] tx, input logic [N-1:0] rx);
    @(negedge clk);
    tx_word = tx; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    done_cnt = 0;
    ssel_n_i = 0;
    repeat (HP) @(negedge clk);
    chk(dx_oe == 0, "R11 oe low before first edge", dx_oe, 0);
    for (int k = 0; k < N; k++) begin
      sclk_i = 1;
      repeat (2) @(negedge clk);
      dr_i = rx[N-1-k];
      repeat (8) @(negedge clk);
      chk(dx_oe == 1 && dx_o == tx[N-1-k], "R10 slave dx bit", {dx_oe, dx_o}, {1'b1, tx[N-1-k]});
      chk(sclk_o == 0 && ssel_n_o == 1, "R10 slave outputs idle", {sclk_o, ssel_n_o}, 1);
      repeat (2) @(negedge clk);
      sclk_i = 0;
      repeat (HP) @(negedge clk);
    end
    chk(done_cnt == 1, "R10 slave done count", done_cnt, 1);
    chk(rx_word == rx, "R10 slave rx_word", rx_word, rx);
    ssel_n_i = 1;
    repeat (HP) @(negedge clk);
    chk(dx_oe == 0, "R11 oe released", dx_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ssel_n_o == 1 && sclk_o == 0 && dx_oe == 0 && done == 0 && rx_word == 0,
        "R1 reset state", {ssel_n_o, sclk_o, dx_oe, done, rx_word}, 12'h800);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ssel_n_o == 1 && sclk_o == 0, "R1 idle after reset", {ssel_n_o, sclk_o}, 2);

    run_master(8'hA5, 8'h3C, 1, 0);
    run_master(8'h81, 8'hE7, 4, 0);
    run_master(8'h5A, 8'hC3, 0, 0);
    run_master(8'hF0, 8'h0F, 2, 1);
    run_master(8'h69, 8'h96, 3, 2);

    // R8: external reference, 6-cycle period, divider 2 -> T=3, L=1, H=2
    ref_int = 0; ext_on = 1;
    launch(8'h3B, 8'hD2, 2);
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    chk(done_cnt == 1, "R8 ext done", done_cnt, 1);
    chk(rx_word == 8'hD2, "R8 ext rx_word", rx_word, 8'hD2);
    chk(rises == N, "R8 ext pulse count", rises, N);
    chk(rise_c1 - rise_c0 == 18, "R8 ext period", rise_c1 - rise_c0, 18);
    chk(fall_c0 - rise_c0 == 12, "R8 ext high width", fall_c0 - rise_c0, 12);
    ext_on = 0; ref_int = 1;
    repeat (4) @(negedge clk);

    is_master = 0;
    repeat (4) @(negedge clk);
    run_slave(8'hC6, 8'h5D);
    run_slave(8'h1E, 8'hA0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule